// File: doc/BRIEF.md
# Write-Once Critical Temperature Shutdown Controller

This block watches four signed 8-bit temperature readings: three external diode channels (channels 0 to 2) and one internal channel (channel 3). It drives an active-low shutdown output and an alert output. Each channel has a critical limit register that can be written exactly once per power-on reset. That single write both freezes the value and arms the channel for hardware shutdown. Until a channel is armed, its critical limit has no effect.

Each channel also has a freely writable high limit. For the three external channels, a configuration register can link the high limit to the shutdown path. High-limit and critical events are recorded in sticky status registers that clear when read. The alert output reports any unmasked interrupt status bit unless a global mask bit is set.

Software reaches the block through a plain register bus with a write strobe and a read strobe. Read data appears one cycle after the read strobe. The temperature inputs are sampled continuously, so there is no handshake and no back-pressure: each clock edge evaluates the values present on the inputs.

Top module: `thermal_trip_ctrl`

## Requirements
- R1: After power-on reset `shdn_n` is 1, `alert` is 0, the configuration register (20h) reads 00h, and the interrupt status (40h) and critical status (41h) registers read 00h.
- R2: The critical limit registers of channels 0, 1, 2 and 3 sit at 19h, 1Ah, 1Bh and 1Dh. Each reads 64h (+100) until it is written. Values are two's complement, with bit 7 as the sign.
- R3: A channel whose critical limit has never been written never drives `shdn_n` low and never sets its critical status bit, whatever its temperature.
- R4: The first write to a critical limit register stores the value. Every later write to that register is ignored until power-on reset, and reads keep returning the first value.
- R5: Once a channel is armed by that first write, a temperature strictly greater than the limit (signed compare) drives `shdn_n` low at the next clock edge. It also sets bit i of the critical status register (41h) and the critical summary bit 4 of the interrupt status register (40h).
- R6: The high limit registers sit at 30h to 33h for channels 0 to 3 and reset to 55h (+85). A temperature greater than or equal to the high limit sets bit i of the interrupt status register.
- R7: In the configuration register, bits 1, 2 and 3 link the high limit of channels 0, 1 and 2 to shutdown. While a channel is linked, `shdn_n` is 0 one edge after its temperature meets or exceeds the high limit, and 1 again one edge after it falls below. An unlinked channel's high limit never affects `shdn_n`.
- R8: Status bits are sticky. A read of 40h or 41h returns the held bits and clears them. A condition that is still present at that edge sets its bit again.
- R9: `alert` is registered. It is 1 one edge after any interrupt status bit is set whose bit in the interrupt mask register (42h, same bit layout as 40h) is 0. A bit set to 1 in the mask keeps that status bit from raising `alert`, while the status bit is still recorded.
- R10: While configuration bit 7 is 1, `alert` is 0 from the next edge on.
- R11: `shdn_n` returns to 1 one edge after every armed critical condition and every linked high-limit condition has cleared.
- R12: `bus_rdata` holds the addressed register one edge after `bus_rd`. Unmapped addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; the only way to unlock limits |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading a status register clears it) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after `bus_rd` |
| temp_in | input | 32 | Four signed 8-bit temperatures, channel i at bits 8i+7:8i |
| shdn_n | output | 1 | Registered shutdown request, active low |
| alert | output | 1 | Registered alert, active high |

## Verification
The embedded assertions check the following on every cycle:
- An unwritten critical limit still holds its default.
- A locked limit never changes again.
- A lock only ever appears alongside a write to that limit's address.
- An unarmed channel never shows critical status.
- An armed critical hit always pulls `shdn_n` low on the next edge, and `shdn_n` is released once no condition remains.
- Status bits hold until a read clears them.
- The global mask silences `alert`.

Only the bench scenarios can show the following:
- The signed boundaries: strict greater-than for critical, greater-or-equal for high.
- The register addresses and read-back values.
- That a second write to a limit is ignored.
- That a status bit is set again by a condition that persists across a read.
- That a per-bit mask hides one source while the bit is still recorded.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  localparam logic [DW-1:0] CRIT_DEFAULT = 8'h64;
  localparam logic [DW-1:0] HIGH_DEFAULT = 8'h55;

  localparam logic [AW-1:0] CFG_ADDR      = 8'h20;
  localparam logic [AW-1:0] INT_STAT_ADDR = 8'h40;
  localparam logic [AW-1:0] CRIT_STAT_ADDR = 8'h41;
  localparam logic [AW-1:0] INT_MASK_ADDR = 8'h42;
  localparam logic [AW-1:0] HIGH_BASE     = 8'h30;
  localparam logic [AW-1:0] CRIT_BASE     = 8'h19;
  localparam logic [AW-1:0] CRIT_INTERNAL = 8'h1D;

  localparam int CFG_MASK_BIT = 7;

  // Critical limits: external channels are packed from 19h, the internal channel sits at 1Dh.
  function automatic logic [AW-1:0] crit_addr(input int ch, input int n_ext);
    if (ch >= n_ext) return CRIT_INTERNAL;
    return CRIT_BASE + AW'(ch);
  endfunction

  function automatic logic [AW-1:0] high_addr(input int ch);
    return HIGH_BASE + AW'(ch);
  endfunction
endpackage

// File: rtl/ttc_limit_bank.sv
module ttc_limit_bank
  import thermal_trip_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_EXT = 3
) (
  input  logic                         clk,
  input  logic                         por_n,
  input  logic                         wr_en,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  output logic [NUM_CH-1:0][DW-1:0]    crit_lim,
  output logic [NUM_CH-1:0][DW-1:0]    high_lim,
  output logic [NUM_CH-1:0]            armed
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [AW-1:0] CA = crit_addr(i, NUM_EXT);
    localparam logic [AW-1:0] HA = high_addr(i);

    logic crit_hit_wr;
    assign crit_hit_wr = wr_en && (addr == CA) && !armed[i];

    // Write-once limit: the lock flag doubles as the arming flag.
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        crit_lim[i] <= CRIT_DEFAULT;
        armed[i]    <= 1'b0;
      end else if (crit_hit_wr) begin
        crit_lim[i] <= wdata;
        armed[i]    <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        high_lim[i] <= HIGH_DEFAULT;
      end else if (wr_en && (addr == HA)) begin
        high_lim[i] <= wdata;
      end
    end

    a_r2_unwritten_default: assert property (@(posedge clk) disable iff (!por_n)
      !armed[i] |-> crit_lim[i] == CRIT_DEFAULT);

    a_r4_lock_holds: assert property (@(posedge clk) disable iff (!por_n)
      armed[i] |=> armed[i] && $stable(crit_lim[i]));

    a_r5_arm_from_write: assert property (@(posedge clk) disable iff (!por_n)
      $rose(armed[i]) |-> $past(wr_en && addr == CA));
  end

endmodule

// File: rtl/ttc_compare.sv
module ttc_compare
  import thermal_trip_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0][DW-1:0] temp,
  input  logic [NUM_CH-1:0][DW-1:0] crit_lim,
  input  logic [NUM_CH-1:0][DW-1:0] high_lim,
  output logic [NUM_CH-1:0]         crit_hit,
  output logic [NUM_CH-1:0]         high_hit
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_cmp
    // Critical trips strictly above the limit, high trips at or above it.
    assign crit_hit[i] = $signed(temp[i]) >  $signed(crit_lim[i]);
    assign high_hit[i] = $signed(temp[i]) >= $signed(high_lim[i]);
  end

endmodule

// File: rtl/ttc_status.sv
module ttc_status
  import thermal_trip_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [NUM_CH-1:0] crit_hit,
  input  logic [NUM_CH-1:0] high_hit,
  input  logic [NUM_CH-1:0] armed,
  input  logic [NUM_CH-1:0] link,
  input  logic              glob_mask,
  input  logic [NUM_CH:0]   int_mask,
  input  logic              clr_int,
  input  logic              clr_crit,
  output logic [NUM_CH:0]   int_stat,
  output logic [NUM_CH-1:0] crit_stat,
  output logic              shdn_n,
  output logic              alert
);

  localparam int IW = NUM_CH + 1;

  logic [NUM_CH-1:0] crit_armed;
  logic [NUM_CH-1:0] high_linked;
  logic [IW-1:0]     int_set;
  logic [IW-1:0]     int_keep;
  logic [NUM_CH-1:0] crit_keep;
  logic              trip_any;

  assign crit_armed  = crit_hit & armed;
  assign high_linked = high_hit & link;
  assign int_set     = {|crit_armed, high_hit};
  assign int_keep    = clr_int  ? '0 : int_stat;
  assign crit_keep   = clr_crit ? '0 : crit_stat;
  assign trip_any    = (|crit_armed) | (|high_linked);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      int_stat  <= '0;
      crit_stat <= '0;
      shdn_n    <= 1'b1;
      alert     <= 1'b0;
    end else begin
      int_stat  <= int_keep | int_set;
      crit_stat <= crit_keep | crit_armed;
      shdn_n    <= !trip_any;
      alert     <= !glob_mask && |(int_stat & ~int_mask);
    end
  end

  a_r5_trip_pulls_low: assert property (@(posedge clk) disable iff (!por_n)
    |(crit_hit & armed) |=> !shdn_n);

  a_r11_release: assert property (@(posedge clk) disable iff (!por_n)
    !(|(crit_hit & armed)) && !(|(high_hit & link)) |=> shdn_n);

  a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!por_n)
    glob_mask |=> !alert);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    a_r3_unarmed_no_crit: assert property (@(posedge clk) disable iff (!por_n)
      !armed[k] |-> !crit_stat[k]);

    a_r8_crit_sticky: assert property (@(posedge clk) disable iff (!por_n)
      crit_stat[k] && !clr_crit |=> crit_stat[k]);
  end

  for (genvar k = 0; k < IW; k++) begin : g_ichk
    a_r8_int_sticky: assert property (@(posedge clk) disable iff (!por_n)
      int_stat[k] && !clr_int |=> int_stat[k]);
  end

endmodule

// File: rtl/thermal_trip_ctrl.sv
module thermal_trip_ctrl
  import thermal_trip_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_EXT = 3
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_addr,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [NUM_CH*8-1:0]  temp_in,
  output logic                 shdn_n,
  output logic                 alert
);

  localparam int IW = NUM_CH + 1;

  logic [NUM_CH-1:0][DW-1:0] temp;
  logic [NUM_CH-1:0][DW-1:0] crit_lim;
  logic [NUM_CH-1:0][DW-1:0] high_lim;
  logic [NUM_CH-1:0]         armed;
  logic [NUM_CH-1:0]         crit_hit;
  logic [NUM_CH-1:0]         high_hit;
  logic [NUM_CH-1:0]         link;
  logic [NUM_EXT-1:0]        sys_link;
  logic                      glob_mask;
  logic [IW-1:0]             int_mask;
  logic [IW-1:0]             int_stat;
  logic [NUM_CH-1:0]         crit_stat;
  logic [DW-1:0]             rd_val;
  logic                      clr_int;
  logic                      clr_crit;

  assign temp = temp_in;
  assign link = {{(NUM_CH-NUM_EXT){1'b0}}, sys_link};

  ttc_limit_bank #(.NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT)) u_limits (
    .clk      (clk),
    .por_n    (por_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .crit_lim (crit_lim),
    .high_lim (high_lim),
    .armed    (armed)
  );

  ttc_compare #(.NUM_CH(NUM_CH)) u_cmp (
    .temp     (temp),
    .crit_lim (crit_lim),
    .high_lim (high_lim),
    .crit_hit (crit_hit),
    .high_hit (high_hit)
  );

  ttc_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk       (clk),
    .por_n     (por_n),
    .crit_hit  (crit_hit),
    .high_hit  (high_hit),
    .armed     (armed),
    .link      (link),
    .glob_mask (glob_mask),
    .int_mask  (int_mask),
    .clr_int   (clr_int),
    .clr_crit  (clr_crit),
    .int_stat  (int_stat),
    .crit_stat (crit_stat),
    .shdn_n    (shdn_n),
    .alert     (alert)
  );

  // Configuration and interrupt mask registers
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      glob_mask <= 1'b0;
      sys_link  <= '0;
      int_mask  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == CFG_ADDR) begin
        glob_mask <= bus_wdata[CFG_MASK_BIT];
        for (int i = 0; i < NUM_EXT; i++) sys_link[i] <= bus_wdata[i+1];
      end
      if (bus_addr == INT_MASK_ADDR) int_mask <= bus_wdata[IW-1:0];
    end
  end

  assign clr_int  = bus_rd && (bus_addr == INT_STAT_ADDR);
  assign clr_crit = bus_rd && (bus_addr == CRIT_STAT_ADDR);

  always_comb begin
    rd_val = '0;
    if (bus_addr == CFG_ADDR) begin
      rd_val[CFG_MASK_BIT] = glob_mask;
      for (int i = 0; i < NUM_EXT; i++) rd_val[i+1] = sys_link[i];
    end
    if (bus_addr == INT_STAT_ADDR)  rd_val[IW-1:0]     = int_stat;
    if (bus_addr == CRIT_STAT_ADDR) rd_val[NUM_CH-1:0] = crit_stat;
    if (bus_addr == INT_MASK_ADDR)  rd_val[IW-1:0]     = int_mask;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == crit_addr(i, NUM_EXT)) rd_val = crit_lim[i];
      if (bus_addr == high_addr(i))          rd_val = high_lim[i];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

endmodule

// File: tb/thermal_trip_ctrl_test.sv
module thermal_trip_ctrl_test;
  logic clk = 0;
  logic por_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic shdn_n, alert;
  logic [7:0] tv [4];
  logic [31:0] temp_in;
  int checks = 0, fails = 0;

  assign temp_in = {tv[3], tv[2], tv[1], tv[0]};
  always #10 clk = ~clk;

  thermal_trip_ctrl uut (
    .clk(clk), .por_n(por_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .temp_in(temp_in), .shdn_n(shdn_n), .alert(alert));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic rd_drop(input logic [7:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0h expected %0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) tv[i] = 8'd0;
    step(3);
    por_n = 1;
    step(2);
    // R1 reset state
    chk(shdn_n == 1'b1, "R1 shdn_n", shdn_n, 1);
    chk(alert == 1'b0, "R1 alert", alert, 0);
    rd_chk(8'h20, 8'h00, "R1 cfg");
    rd_chk(8'h40, 8'h00, "R1 int status");
    rd_chk(8'h41, 8'h00, "R1 crit status");
    // R2 critical limit defaults
    rd_chk(8'h19, 8'h64, "R2 ch0 limit");
    rd_chk(8'h1A, 8'h64, "R2 ch1 limit");
    rd_chk(8'h1B, 8'h64, "R2 ch2 limit");
    rd_chk(8'h1D, 8'h64, "R2 ch3 limit");
    // R6 high limit defaults
    for (int i = 0; i < 4; i++) rd_chk(8'h30 + 8'(i), 8'h55, "R6 high default");
    rd_chk(8'h99, 8'h00, "R12 unmapped read");

    // R3 hot but unarmed
    for (int i = 0; i < 4; i++) tv[i] = 8'd110;
    step(3);
    chk(shdn_n == 1'b1, "R3 unarmed no shutdown", shdn_n, 1);
    chk(alert == 1'b1, "R9 alert on high status", alert, 1);
    rd_chk(8'h41, 8'h00, "R3 unarmed crit status");
    wr(8'h20, 8'h80);
    step(2);
    chk(alert == 1'b0, "R10 global mask", alert, 0);
    rd_chk(8'h20, 8'h80, "R10 cfg readback");
    wr(8'h20, 8'h00);
    step(2);
    chk(alert == 1'b1, "R9 alert after unmask", alert, 1);
    rd_chk(8'h40, 8'h0F, "R6 high bits set");
    for (int i = 0; i < 4; i++) tv[i] = 8'd0;
    step(1);
    rd_chk(8'h40, 8'h0F, "R8 persisting condition re-set");
    rd_chk(8'h40, 8'h00, "R8 cleared on read");
    step(2);
    chk(alert == 1'b0, "R9 alert idle", alert, 0);

    // R9 per-bit mask
    wr(8'h42, 8'h04);
    tv[2] = 8'd110;
    step(3);
    chk(alert == 1'b0, "R9 masked bit no alert", alert, 0);
    rd_chk(8'h40, 8'h04, "R9 masked bit recorded");
    tv[2] = 8'd0;
    step(1);
    rd_drop(8'h40);
    wr(8'h42, 8'h00);

    // R4 write-once lock, R5 arming
    wr(8'h19, 8'h50);
    rd_chk(8'h19, 8'h50, "R4 first write stored");
    wr(8'h19, 8'h10);
    rd_chk(8'h19, 8'h50, "R4 second write ignored");
    chk(shdn_n == 1'b1, "R5 cool armed channel", shdn_n, 1);
    for (int t = -128; t < 128; t++) begin
      @(negedge clk); tv[0] = 8'(t);
      step(1);
      chk(shdn_n == ((t > 80) ? 1'b0 : 1'b1), "R5 ch0 sweep", shdn_n, (t > 80) ? 0 : 1);
    end
    rd_chk(8'h41, 8'h01, "R5 crit status bit");
    rd_chk(8'h40, 8'h11, "R5 TCRIT summary bit");
    tv[0] = 8'd0;
    step(1);
    chk(shdn_n == 1'b1, "R11 release", shdn_n, 1);
    rd_chk(8'h41, 8'h01, "R8 crit sticky");
    rd_chk(8'h41, 8'h00, "R8 crit cleared");
    rd_drop(8'h40);
    rd_chk(8'h40, 8'h00, "R8 int cleared");

    // R5 negative limit on internal channel
    tv[3] = 8'(-20);
    wr(8'h1D, 8'hF6);
    for (int t = -20; t <= 0; t++) begin
      @(negedge clk); tv[3] = 8'(t);
      step(1);
      chk(shdn_n == ((t > -10) ? 1'b0 : 1'b1), "R5 ch3 signed sweep", shdn_n, (t > -10) ? 0 : 1);
    end
    tv[3] = 8'(-20);
    step(1);
    rd_chk(8'h41, 8'h08, "R5 ch3 crit status");
    wr(8'h1D, 8'h00);
    rd_chk(8'h1D, 8'hF6, "R4 ch3 lock");

    // R7 linked high limit on ch1
    wr(8'h31, 8'h3C);
    wr(8'h20, 8'h04);
    rd_chk(8'h20, 8'h04, "R7 cfg readback");
    for (int t = -128; t < 128; t++) begin
      @(negedge clk); tv[1] = 8'(t);
      step(1);
      chk(shdn_n == ((t >= 60) ? 1'b0 : 1'b1), "R7 ch1 linked sweep", shdn_n, (t >= 60) ? 0 : 1);
    end
    tv[1] = 8'd100;
    wr(8'h20, 8'h00);
    step(1);
    chk(shdn_n == 1'b1, "R7 unlinked high ignored", shdn_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule